// File: doc/BRIEF.md
# Prescaled Reload Down-Timer

This block is a 32-bit down-counting timer. A 32-bit divide-down prescaler turns the input clock into timer ticks, one every (divide value + 1) clocks. The counter drops by one on each tick. When the counter is already zero, the next tick loads it from a 32-bit period value and raises a one-clock interrupt pulse. Software can also force a reload at any time through a control bit. A stop bit freezes both the prescaler and the counter.

All state sits behind a 16-bit register bus with a 3-bit word address. Each 32-bit quantity (count, period, divide value) is exposed as a low half and a high half. Reads are combinational from the address. Writes take effect at the next rising clock edge while the write strobe is high.

Top module: `reload_down_timer`

## Requirements
- R1: Word addresses are: 0 count low, 1 count high, 2 period low, 3 period high, 4 control, 5 reserved, 6 divide low, 7 divide high. A value written to the count, period or divide halves reads back unchanged while the timer is stopped.
- R2: After synchronous reset, count low and period low read 0xFFFF. Count high, period high, both divide halves and control read 0x0000, and the interrupt output is 0.
- R3: While running, the counter decrements once every (D + 1) clocks, where D is {divide high, divide low}.
- R4: The count is one 32-bit value: a decrement from 0x0001_0000 gives 0x0000_FFFF.
- R5: On a tick that finds the count at zero, the count is loaded with {period high, period low} instead of being decremented.
- R6: The interrupt output is high for exactly one clock: the first cycle in which the count shows the value reloaded by R5. A forced reload raises no interrupt.
- R7: Writing control with bit 5 set copies the period into the count and restarts the prescaler, so the next tick follows D + 1 clocks later. Bit 5 always reads 0.
- R8: Control bit 4 is the stop bit and reads back as written. While it is 1, the prescaler and the count hold their values.
- R9: A bus write to a count half takes precedence over a tick in the same clock.
- R10: Address 5 reads 0. Writes to it change no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| tmr_irq | output | 1 | One-clock interrupt pulse on reload from the period |

## Verification
Reads are combinational, so a read result belongs to the same cycle its address is driven in. A write becomes visible in the cycle after its strobe. A tick changes the count at the edge that ends the tick cycle. The interrupt is high in the first cycle that shows the reloaded count. Each scoreboard entry is therefore compared midway between a falling edge and the following rising edge, in the cycle the driver placed it. Sequences that depend on ticks are started from a forced reload or from a known stopped prescaler state, so that every expected count can be worked out from the clock index alone.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int BUS_W  = 16;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int ADDR_W = 3;

    localparam int CTL_STOP_BIT   = 4;
    localparam int CTL_RELOAD_BIT = 5;

    typedef logic [CNT_W-1:0] word_t;
    typedef logic [BUS_W-1:0] half_t;

    localparam word_t CNT_RST = word_t'({BUS_W{1'b1}});
    localparam word_t PRD_RST = word_t'({BUS_W{1'b1}});
    localparam word_t DIV_RST = '0;

    typedef enum logic [ADDR_W-1:0] {
        RG_CNT_LO = 3'd0,
        RG_CNT_HI = 3'd1,
        RG_PRD_LO = 3'd2,
        RG_PRD_HI = 3'd3,
        RG_CTRL   = 3'd4,
        RG_RSVD   = 3'd5,
        RG_DIV_LO = 3'd6,
        RG_DIV_HI = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        half_t    data;
    } bus_req_t;

    function automatic word_t put_half(word_t w, logic hi, half_t d);
        if (hi) return {d, w[BUS_W-1:0]};
        return {w[CNT_W-1:BUS_W], d};
    endfunction

    function automatic half_t get_half(word_t w, logic hi);
        if (hi) return w[CNT_W-1:BUS_W];
        return w[BUS_W-1:0];
    endfunction

endpackage

// File: rtl/rdt_regs.sv
module rdt_regs
    import rdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    input  word_t    cnt_i,
    output word_t    prd_o,
    output word_t    div_o,
    output logic     stop_o,
    output logic     force_ld_o,
    output logic     wr_cnt_lo_o,
    output logic     wr_cnt_hi_o,
    output half_t    rdata_o
);

    word_t prd_q, div_q;
    logic  stop_q;

    assign prd_o       = prd_q;
    assign div_o       = div_q;
    assign stop_o      = stop_q;
    assign force_ld_o  = req_i.wr && (req_i.sel == RG_CTRL) && req_i.data[CTL_RELOAD_BIT];
    assign wr_cnt_lo_o = req_i.wr && (req_i.sel == RG_CNT_LO);
    assign wr_cnt_hi_o = req_i.wr && (req_i.sel == RG_CNT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_q  <= PRD_RST;
            div_q  <= DIV_RST;
            stop_q <= 1'b0;
        end else if (req_i.wr) begin
            case (req_i.sel)
                RG_PRD_LO: prd_q  <= put_half(prd_q, 1'b0, req_i.data);
                RG_PRD_HI: prd_q  <= put_half(prd_q, 1'b1, req_i.data);
                RG_DIV_LO: div_q  <= put_half(div_q, 1'b0, req_i.data);
                RG_DIV_HI: div_q  <= put_half(div_q, 1'b1, req_i.data);
                RG_CTRL:   stop_q <= req_i.data[CTL_STOP_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (req_i.sel)
            RG_CNT_LO: rdata_o = get_half(cnt_i, 1'b0);
            RG_CNT_HI: rdata_o = get_half(cnt_i, 1'b1);
            RG_PRD_LO: rdata_o = get_half(prd_q, 1'b0);
            RG_PRD_HI: rdata_o = get_half(prd_q, 1'b1);
            RG_CTRL:   rdata_o[CTL_STOP_BIT] = stop_q;
            RG_DIV_LO: rdata_o = get_half(div_q, 1'b0);
            RG_DIV_HI: rdata_o = get_half(div_q, 1'b1);
            default:   rdata_o = '0;
        endcase
    end

    // R10: a write to the reserved word leaves all configuration untouched
    a_r10_rsvd_no_effect: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.sel == RG_RSVD) |=> ($stable(prd_q) && $stable(div_q) && $stable(stop_q)));

endmodule

// File: rtl/rdt_prescaler.sv
module rdt_prescaler
    import rdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_i,
    input  logic  restart_i,
    input  word_t div_i,
    output logic  tick_o
);

    word_t psc_q;

    assign tick_o = !stop_i && (psc_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= DIV_RST;
        end else if (restart_i) begin
            psc_q <= div_i;
        end else if (!stop_i) begin
            if (psc_q == '0) psc_q <= div_i;
            else             psc_q <= psc_q - word_t'(1);
        end
    end

    // R8: a stopped prescaler keeps its count
    a_r8_psc_hold: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !restart_i) |=> $stable(psc_q));

    // R7: a forced reload restarts the divide-down sequence from the full value
    a_r7_psc_restart: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (psc_q == $past(div_i)));

endmodule

// File: rtl/rdt_counter.sv
module rdt_counter
    import rdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  force_ld_i,
    input  logic  wr_lo_i,
    input  logic  wr_hi_i,
    input  half_t wdata_i,
    input  word_t prd_i,
    output word_t cnt_o,
    output logic  irq_o
);

    word_t cnt_q;
    logic  at_zero, bus_wr;

    assign at_zero = (cnt_q == '0);
    assign bus_wr  = wr_lo_i || wr_hi_i;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_RST;
            irq_o <= 1'b0;
        end else begin
            irq_o <= tick_i && at_zero && !force_ld_i && !bus_wr;
            if (force_ld_i) begin
                cnt_q <= prd_i;
            end else if (bus_wr) begin
                if (wr_lo_i) cnt_q[BUS_W-1:0]     <= wdata_i;
                if (wr_hi_i) cnt_q[CNT_W-1:BUS_W] <= wdata_i;
            end else if (tick_i) begin
                cnt_q <= at_zero ? prd_i : cnt_q - word_t'(1);
            end
        end
    end

    // R3: a tick on a nonzero count lowers it by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !at_zero && !force_ld_i && !bus_wr) |=> (cnt_q == $past(cnt_q) - word_t'(1)));

    // R5: a tick on a zero count loads the period
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (tick_i && at_zero && !force_ld_i && !bus_wr) |=> (cnt_q == $past(prd_i)));

    // R6: the interrupt follows only a natural reload
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(tick_i && at_zero && !force_ld_i && !bus_wr));

    // R8: no tick and no write means the count holds
    a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !force_ld_i && !bus_wr) |=> $stable(cnt_q));

    // R7: a forced reload copies the period
    a_r7_force: assert property (@(posedge clk) disable iff (rst)
        force_ld_i |=> (cnt_q == $past(prd_i) && !irq_o));

endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
    import rdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tmr_irq
);

    bus_req_t req;
    word_t    cnt, prd, div;
    logic     stop, force_ld, wr_lo, wr_hi, tick;

    assign req.wr   = bus_wr;
    assign req.sel  = reg_sel_e'(bus_addr);
    assign req.data = bus_wdata;

    rdt_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .cnt_i       (cnt),
        .prd_o       (prd),
        .div_o       (div),
        .stop_o      (stop),
        .force_ld_o  (force_ld),
        .wr_cnt_lo_o (wr_lo),
        .wr_cnt_hi_o (wr_hi),
        .rdata_o     (bus_rdata)
    );

    rdt_prescaler u_psc (
        .clk       (clk),
        .rst       (rst),
        .stop_i    (stop),
        .restart_i (force_ld),
        .div_i     (div),
        .tick_o    (tick)
    );

    rdt_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .force_ld_i (force_ld),
        .wr_lo_i    (wr_lo),
        .wr_hi_i    (wr_hi),
        .wdata_i    (bus_wdata),
        .prd_i      (prd),
        .cnt_o      (cnt),
        .irq_o      (tmr_irq)
    );

    // R10: the reserved word never returns data
    a_r10_rsvd_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd5) |-> (bus_rdata == '0));

    // R2: the first cycle after reset carries no interrupt
    a_r2_no_irq_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !tmr_irq);

endmodule

// File: tb/reload_down_timer_tb_top.sv
module reload_down_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tmr_irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [2:0]  addr;
        logic [15:0] data;
        logic        irq;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    reload_down_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    // driver: called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] d, input logic irq, input string req);
        item_t it;
        bus_addr = a;
        it.addr = a;
        it.data = d;
        it.irq  = irq;
        it.req  = req;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // monitor: compares mid-cycle, after the driver has settled the address
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                vectors++;
                if (bus_rdata !== it.data || tmr_irq !== it.irq) begin
                    misses++;
                    $display("FAIL %s addr=%0d actual data=%h irq=%b expected data=%h irq=%b",
                             it.req, it.addr, bus_rdata, tmr_irq, it.data, it.irq);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R2: reset values, read while reset is held
        chk(3'd0, 16'hFFFF, 1'b0, "R2");
        chk(3'd1, 16'h0000, 1'b0, "R2");
        chk(3'd2, 16'hFFFF, 1'b0, "R2");
        chk(3'd3, 16'h0000, 1'b0, "R2");
        chk(3'd4, 16'h0000, 1'b0, "R2");
        chk(3'd6, 16'h0000, 1'b0, "R2");
        chk(3'd7, 16'h0000, 1'b0, "R2");
        rst = 1'b0;
        @(negedge clk);

        // R8: stop, then the count holds
        wr(3'd4, 16'h0010);
        chk(3'd4, 16'h0010, 1'b0, "R8");
        wr(3'd0, 16'h1234);
        chk(3'd0, 16'h1234, 1'b0, "R8");
        chk(3'd0, 16'h1234, 1'b0, "R8");
        chk(3'd0, 16'h1234, 1'b0, "R8");

        // R7: forced reload while stopped, reload bit reads 0, no interrupt
        wr(3'd4, 16'h0030);
        chk(3'd4, 16'h0010, 1'b0, "R7");
        chk(3'd0, 16'hFFFF, 1'b0, "R7");
        chk(3'd1, 16'h0000, 1'b0, "R7");

        // R1: read-back of every writable half
        wr(3'd7, 16'hABCD);
        chk(3'd7, 16'hABCD, 1'b0, "R1");
        wr(3'd7, 16'h0000);
        wr(3'd6, 16'h0000);
        wr(3'd3, 16'h5A5A);
        chk(3'd3, 16'h5A5A, 1'b0, "R1");
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h0003);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0005);
        chk(3'd2, 16'h0003, 1'b0, "R1");
        chk(3'd0, 16'h0005, 1'b0, "R1");
        chk(3'd6, 16'h0000, 1'b0, "R1");

        // R5/R6: divide 0, count 5 -> 0, reload to 3 with a single pulse
        wr(3'd4, 16'h0000);
        for (int k = 0; k < 6; k++) chk(3'd0, 16'(5 - k), 1'b0, "R5");
        chk(3'd0, 16'h0003, 1'b1, "R6");
        chk(3'd0, 16'h0002, 1'b0, "R6");

        // R3: divide 2, restart by forced reload to period 4
        wr(3'd2, 16'h0004);
        wr(3'd6, 16'h0002);
        wr(3'd4, 16'h0020);
        for (int k = 1; k <= 17; k++) begin
            int ticks;
            ticks = (k - 1) / 3;
            chk(3'd0, (ticks < 5) ? 16'(4 - ticks) : 16'h0004, (k == 16), "R3");
        end

        // R9: a count write beats the tick of the same cycle
        wr(3'd4, 16'h0010);
        wr(3'd6, 16'h0000);
        wr(3'd2, 16'h1000);
        wr(3'd4, 16'h0020);
        wr(3'd0, 16'h0100);
        chk(3'd0, 16'h0100, 1'b0, "R9");
        chk(3'd0, 16'h00FF, 1'b0, "R9");

        // R4: borrow across the halves
        wr(3'd4, 16'h0010);
        wr(3'd1, 16'h0001);
        wr(3'd0, 16'h0000);
        chk(3'd0, 16'h0000, 1'b0, "R4");
        wr(3'd4, 16'h0000);
        chk(3'd1, 16'h0001, 1'b0, "R4");
        chk(3'd1, 16'h0000, 1'b0, "R4");
        chk(3'd0, 16'hFFFE, 1'b0, "R4");

        // R10: reserved word
        wr(3'd4, 16'h0010);
        wr(3'd2, 16'h0055);
        wr(3'd5, 16'hFFFF);
        chk(3'd5, 16'h0000, 1'b0, "R10");
        chk(3'd2, 16'h0055, 1'b0, "R10");
        chk(3'd3, 16'h0000, 1'b0, "R10");
        chk(3'd4, 16'h0010, 1'b0, "R10");
        chk(3'd6, 16'h0000, 1'b0, "R10");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule